// File: doc/BRIEF.md
# Asynchronous Serial Port with Address-Marking Bit

This block is a full-duplex asynchronous serial port. A character can carry one extra bit after its data bits, and that bit tags the character as an address or as data. Several receivers on a shared line can use it to pick out the characters meant for them. The bit rate comes from an 8-bit rate register and a 2-bit prescale select. Each bit is split into 16 rate ticks, and the receiver samples the line at the middle tick.

The transmitter takes a character and its outgoing tag bit through a ready/valid handshake. The receiver keeps the last character and a full flag, which a read strobe clears. It also holds a read-only copy of the last received tag bit and reports framing and overrun errors for the last character. A mode input selects synchronous operation. In that mode both directions stay idle, because clocked transfer is not part of this block.

Top module: `mp_uart`

## Requirements
- R1: The rate register reads 0xFF after reset and returns the last written value from the cycle after any write, busy or not.
- R2: One bit lasts 16*(N+1)*P system clocks. N is the rate register value and P is 1, 4, 16 or 64 for `clk_sel` values 0, 1, 2 and 3.
- R3: A frame on `txd` has these bits in order: a low start bit; 8 data bits, or 7 when `data7`=1, least significant first; the tag bit taken from `tx_mpbit`, only when `mp_en`=1; then 1 stop bit, or 2 when `two_stop`=1, both high.
- R4: `tx_mpbit` has no effect when `mp_en`=0, because the frame then has no tag bit. It also has no effect while no character is being sent, and `txd` stays high.
- R5: With `sync_mode`=1, `tx_ready` stays 0, `txd` stays high, and line activity leaves `rx_valid` at 0.
- R6: When a character completes, `rx_valid` rises and `rx_data` holds its data bits. Bit 7 is 0 when `data7`=1.
- R7: `rx_mpb` changes only when a character completes with `mp_en`=1. While `rx_en`=0 it keeps its value. The block has no write path to it.
- R8: `rx_ferr` is 1 after a character whose first stop bit was sampled low, and 0 after a character whose first stop bit was sampled high.
- R9: If a character completes while `rx_valid`=1 and `rx_rd`=0, `rx_overrun` becomes 1 and `rx_data` keeps the unread character.
- R10: If the completion and `rx_rd` fall in the same cycle, the new character is stored, `rx_valid` stays 1 and `rx_overrun` is 0.
- R11: A pulse on `rx_rd` in a cycle with no completion clears `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = synchronous mode (both directions idle) |
| mp_en | input | 1 | Adds the tag bit to each frame |
| data7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| two_stop | input | 1 | 1 = two stop bits on transmit |
| rx_en | input | 1 | Receiver enable |
| clk_sel | input | 2 | Prescale select: divide by 1, 4, 16 or 64 |
| brr_we | input | 1 | Rate register write strobe |
| brr_wdata | input | 8 | Rate register write value |
| brr_rdata | output | 8 | Rate register value |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 8 | Transmit character |
| tx_mpbit | input | 1 | Tag bit for the outgoing character |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Receive register full |
| rx_rd | input | 1 | Read strobe, consumes the received character |
| rx_data | output | 8 | Received character |
| rx_mpb | output | 1 | Last received tag bit (read-only) |
| rx_ferr | output | 1 | Framing error for the last character |
| rx_overrun | output | 1 | Overrun for the last character |

## Verification
The two events that can fall in one cycle are the end of a received character and the read strobe that drains the previous one. The bench always leaves one character unread. It then sends a second one over the looped-back line and moves a one-cycle read pulse through every cycle of a window around the expected completion. Each placement must give one of two outcomes: the new character stored with no overrun, or an overrun with the old character kept and then read out. Both outcomes must occur during the sweep, and any other state counts as a mismatch.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = 12;
  localparam int PRE_W   = 6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

  // last count of the prescaler for a given select (divide by 1, 4, 16, 64)
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd0;
      2'd1:    return 6'd3;
      2'd2:    return 6'd15;
      default: return 6'd63;
    endcase
  endfunction

  // number of bits between start and stop (data plus optional tag)
  function automatic logic [3:0] body_bits(input logic d7, input logic mp_on);
    return (d7 ? 4'd7 : 4'd8) + {3'b000, mp_on};
  endfunction

  // whole frame length in bits
  function automatic logic [3:0] frame_len(input logic d7, input logic mp_on, input logic two);
    return 4'd1 + body_bits(d7, mp_on) + (two ? 4'd2 : 4'd1);
  endfunction

  // frame image, bit 0 goes out first; unused upper bits are stop level
  function automatic logic [FRAME_W-1:0] tx_frame(input logic [CHAR_W-1:0] d, input logic mpb,
                                                  input logic mp_on, input logic d7);
    logic [FRAME_W-1:0] f;
    int p;
    f    = '1;
    f[0] = 1'b0;
    p    = 1;
    for (int i = 0; i < CHAR_W; i++) begin
      if (!(d7 && i == CHAR_W-1)) begin
        f[p] = d[i];
        p++;
      end
    end
    if (mp_on) f[p] = mpb;
    return f;
  endfunction
endpackage

// File: rtl/mp_uart_baud.sv
module mp_uart_baud
  import mp_uart_pkg::*;
#(
  parameter int BRR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic [BRR_W-1:0] brr,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [BRR_W-1:0] rate_cnt;
  logic             pre_tick;

  assign pre_tick = (pre_cnt >= presc_last(clk_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      tick     <= 1'b0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      tick    <= pre_tick && (rate_cnt == '0);
      if (pre_tick) rate_cnt <= (rate_cnt == '0) ? brr : rate_cnt - 1'b1;
    end
  end

  // R2: with a prescale of 4 or more, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick && clk_sel != 2'd0 && $stable(clk_sel) |=> !tick);
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              mp_en,
  input  logic              data7,
  input  logic              two_stop,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_mpbit,
  output logic              tx_ready,
  output logic              txd
);
  localparam int CW = $clog2(OVS);

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bits_left;
  logic [CW-1:0]      tcnt;
  logic               busy, tx_accept, bit_end;

  assign busy      = (bits_left != 4'd0);
  assign tx_ready  = enable && !busy;
  assign tx_accept = tx_valid && tx_ready;
  assign bit_end   = busy && tick && (tcnt == CW'(OVS-1));
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= 4'd0;
      tcnt      <= '0;
    end else if (tx_accept) begin
      shreg     <= tx_frame(tx_data, tx_mpbit, mp_en, data7);
      bits_left <= frame_len(data7, mp_en, two_stop);
      tcnt      <= '0;
    end else if (busy && tick) begin
      if (bit_end) begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 4'd1;
        tcnt      <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R3: an accepted character starts with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !txd && !tx_ready);
  // R4: with nothing in flight the line is high whatever tx_mpbit does
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !tx_accept |=> txd);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              mp_en,
  input  logic              data7,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_mpb,
  output logic              rx_ferr,
  output logic              rx_overrun
);
  localparam int CW = $clog2(OVS);

  rx_state_t       state;
  logic            rs1, rs2;
  logic [CW-1:0]   tcnt;
  logic [3:0]      bidx, nbits;
  logic [CHAR_W:0] shreg, aligned;
  logic [CHAR_W-1:0] char_in;
  logic            rx_done, lost;

  assign nbits   = body_bits(data7, mp_en);
  assign aligned = shreg >> (4'd9 - nbits);
  assign char_in = data7 ? {1'b0, aligned[CHAR_W-2:0]} : aligned[CHAR_W-1:0];
  assign rx_done = (state == RX_STOP) && tick && (tcnt == CW'(OVS-1));
  assign lost    = rx_full && !rx_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b1;
      rs2   <= 1'b1;
      state <= RX_IDLE;
      tcnt  <= '0;
      bidx  <= 4'd0;
      shreg <= '0;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
      if (!enable) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (!rs2) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tick) begin
            if (tcnt == CW'(OVS/2-1)) begin
              state <= rs2 ? RX_IDLE : RX_BITS;
              tcnt  <= '0;
              bidx  <= 4'd0;
            end else tcnt <= tcnt + 1'b1;
          end
          RX_BITS: if (tick) begin
            if (tcnt == CW'(OVS-1)) begin
              shreg <= {rs2, shreg[CHAR_W:1]};
              tcnt  <= '0;
              if (bidx == nbits - 4'd1) state <= RX_STOP;
              else bidx <= bidx + 4'd1;
            end else tcnt <= tcnt + 1'b1;
          end
          default: if (tick) begin
            if (tcnt == CW'(OVS-1)) begin
              state <= RX_IDLE;
              tcnt  <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_full    <= 1'b0;
      rx_mpb     <= 1'b0;
      rx_ferr    <= 1'b0;
      rx_overrun <= 1'b0;
    end else if (rx_done) begin
      rx_ferr    <= !rs2;
      rx_overrun <= lost;
      if (!lost) begin
        rx_data <= char_in;
        rx_full <= 1'b1;
        if (mp_en) rx_mpb <= shreg[CHAR_W];
      end
    end else if (rx_rd) begin
      rx_full <= 1'b0;
    end
  end

  // R7: the tag status moves only on a completed character
  a_r7_mpb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_mpb));
  // R9: an unread character is kept when the next one is lost
  a_r9_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full && !rx_rd |=> rx_overrun && rx_full && $stable(rx_data));
  // R10: read and completion together store the new character without overrun
  a_r10_read_race: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_rd |=> rx_full && !rx_overrun);
  // R11: a read with no completion empties the register
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_done |=> !rx_full);
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int BRR_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             mp_en,
  input  logic             data7,
  input  logic             two_stop,
  input  logic             rx_en,
  input  logic [1:0]       clk_sel,
  input  logic             brr_we,
  input  logic [BRR_W-1:0] brr_wdata,
  output logic [BRR_W-1:0] brr_rdata,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  input  logic             tx_mpbit,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_valid,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_mpb,
  output logic             rx_ferr,
  output logic             rx_overrun
);
  logic [BRR_W-1:0] brr_q;
  logic             tick;
  logic             async_on;

  assign async_on  = !sync_mode;
  assign brr_rdata = brr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brr_q <= '1;
    else if (brr_we) brr_q <= brr_wdata;
  end

  mp_uart_baud #(.BRR_W(BRR_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .brr(brr_q), .tick(tick)
  );

  mp_uart_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(async_on),
    .mp_en(mp_en), .data7(data7), .two_stop(two_stop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpbit(tx_mpbit),
    .tx_ready(tx_ready), .txd(txd)
  );

  mp_uart_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(async_on && rx_en),
    .mp_en(mp_en), .data7(data7), .rxd(rxd), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_valid), .rx_mpb(rx_mpb),
    .rx_ferr(rx_ferr), .rx_overrun(rx_overrun)
  );

  // R1: a write is visible on the read port in the next cycle
  a_r1_brr_write: assert property (@(posedge clk) disable iff (!rst_n)
    brr_we |=> brr_rdata == $past(brr_wdata));
  // R5: synchronous mode never offers the transmitter
  a_r5_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !tx_ready);
endmodule

// File: tb/test_mp_uart.sv
module test_mp_uart;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, mp_en = 1'b0, data7 = 1'b0, two_stop = 1'b0, rx_en = 1'b1;
  logic [1:0] clk_sel = 2'd0;
  logic brr_we = 1'b0;
  logic [7:0] brr_wdata = 8'h00, brr_rdata;
  logic tx_valid = 1'b0, tx_mpbit = 1'b0, tx_ready, txd;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic use_loop = 1'b1, rx_drive = 1'b1, rxd;
  logic rx_valid, rx_rd = 1'b0, rx_mpb, rx_ferr, rx_overrun;
  int n_cmp = 0, n_bad = 0;
  logic exp_mpb = 1'b0;

  always #4 clk = ~clk;
  assign rxd = use_loop ? txd : rx_drive;

  mp_uart i_mp_uart (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .mp_en(mp_en), .data7(data7),
    .two_stop(two_stop), .rx_en(rx_en), .clk_sel(clk_sel), .brr_we(brr_we),
    .brr_wdata(brr_wdata), .brr_rdata(brr_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_mpbit(tx_mpbit), .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_ferr(rx_ferr),
    .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // expected frame assembled field by field: {stops, tag, data, start}
  function automatic logic [11:0] bench_frame(input logic [7:0] d, input logic mp);
    logic [11:0] e;
    e = 12'hFFF;
    e[0] = 1'b0;
    if (data7) e[7:1] = d[6:0];
    else       e[8:1] = d;
    if (mp_en) e[data7 ? 8 : 9] = mp;
    return e;
  endfunction

  function automatic int bench_len();
    return 2 + (data7 ? 7 : 8) + (mp_en ? 1 : 0) + (two_stop ? 1 : 0);
  endfunction

  task automatic brr_write(input logic [7:0] v);
    @(negedge clk); brr_we = 1'b1; brr_wdata = v;
    @(negedge clk); brr_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic mp);
    @(negedge clk); tx_valid = 1'b1; tx_data = d; tx_mpbit = mp;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic dec(input int t, input int len, output logic [11:0] got);
    got = 12'hFFF;
    @(negedge txd);
    repeat (8*t) @(posedge clk);
    #1 got[0] = txd;
    for (int i = 1; i < len; i++) begin
      repeat (16*t) @(posedge clk);
      #1 got[i] = txd;
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic mp, input int t, input string req);
    logic [11:0] got, e, m;
    int len;
    e = bench_frame(d, mp);
    len = bench_len();
    m = 12'((13'h1 << len) - 1);
    fork
      send(d, mp);
      dec(t, len, got);
    join
    chk((got & m) == (e & m), req, {20'h0, got & m}, {20'h0, e & m});
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] d, input logic mp, input int t);
    logic [7:0] ed;
    repeat (16*t + 8) @(negedge clk);
    ed = data7 ? {1'b0, d[6:0]} : d;
    chk(rx_valid == 1'b1, "R6 rx_valid", {31'h0, rx_valid}, 1);
    chk(rx_data == ed, "R6 rx_data", {24'h0, rx_data}, {24'h0, ed});
    if (mp_en) exp_mpb = mp;
    chk(rx_mpb == exp_mpb, "R7 rx_mpb", {31'h0, rx_mpb}, {31'h0, exp_mpb});
    chk(rx_ferr == 1'b0, "R8 ferr clear", {31'h0, rx_ferr}, 0);
    rx_read();
    chk(rx_valid == 1'b0, "R11 read clears", {31'h0, rx_valid}, 0);
  endtask

  task automatic drive_rx(input logic [11:0] b, input int len, input int low_stop_cycles);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_drive = b[i];
      repeat (15) @(negedge clk);
    end
    if (low_stop_cycles > 0) begin
      @(negedge clk); rx_drive = 1'b0;
      repeat (low_stop_cycles - 1) @(negedge clk);
    end
    @(negedge clk); rx_drive = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic period_check(input int t, input string req);
    int n;
    n = 0;
    mp_en = 1'b0; data7 = 1'b0; two_stop = 1'b0;
    fork
      send(8'h00, 1'b0);
      begin
        @(negedge txd);
        while (txd == 1'b0) begin
          @(posedge clk); #1 n++;
        end
      end
    join
    chk((n >= 144*t - t - 2) && (n <= 144*t + 2), req, n, 144*t);
    repeat (32*t) @(negedge clk);
    rx_read();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    logic ok_flag;
    logic [7:0] d, a;
    logic mp;
    int seen_new, seen_lost;
    void'($urandom(32'd7717));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(brr_rdata == 8'hFF, "R1 reset value", {24'h0, brr_rdata}, 32'hFF);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R4 reset idle", {30'h0, txd, tx_ready}, 3);
    chk(rx_valid == 1'b0 && rx_mpb == 1'b0, "R6 reset empty", {30'h0, rx_valid, rx_mpb}, 0);

    brr_write(8'h5A);
    chk(brr_rdata == 8'h5A, "R1 write", {24'h0, brr_rdata}, 32'h5A);
    brr_write(8'h00);
    chk(brr_rdata == 8'h00, "R1 write zero", {24'h0, brr_rdata}, 0);

    // R4: toggling the tag input while idle leaves the line high
    ok_flag = 1'b1;
    mp_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); tx_mpbit = ~tx_mpbit;
      if (txd !== 1'b1) ok_flag = 1'b0;
    end
    chk(ok_flag, "R4 idle tag ignored", {31'h0, ok_flag}, 1);

    // R5: synchronous mode keeps both directions quiet
    sync_mode = 1'b1; use_loop = 1'b0; ok_flag = 1'b1;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h3C;
    rx_drive = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_ready !== 1'b0 || txd !== 1'b1) ok_flag = 1'b0;
    end
    tx_valid = 1'b0; rx_drive = 1'b1;
    repeat (40) @(negedge clk);
    chk(ok_flag, "R5 sync tx idle", {31'h0, ok_flag}, 1);
    chk(rx_valid == 1'b0, "R5 sync rx idle", {31'h0, rx_valid}, 0);
    sync_mode = 1'b0; use_loop = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R6/R7: random formats looped back
    for (int k = 0; k < 16; k++) begin
      mp_en = 1'($urandom); data7 = 1'($urandom); two_stop = 1'($urandom);
      d = 8'($urandom); mp = 1'($urandom);
      xfer(d, mp, 1, "R3 frame");
      rx_expect(d, mp, 1);
    end

    // R7: receiver off keeps the tag status
    mp_en = 1'b1; data7 = 1'b0; two_stop = 1'b0; rx_en = 1'b0;
    xfer(8'hC3, ~exp_mpb, 1, "R3 frame rx off");
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 rx off no char", {31'h0, rx_valid}, 0);
    chk(rx_mpb == exp_mpb, "R7 rx off holds", {31'h0, rx_mpb}, {31'h0, exp_mpb});
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R4: format off, no tag bit on the line and status untouched
    mp_en = 1'b0;
    xfer(8'h81, ~exp_mpb, 1, "R4 no tag bit");
    rx_expect(8'h81, ~exp_mpb, 1);

    // R8: low stop bit, then a clean character
    use_loop = 1'b0;
    drive_rx({3'b111, 8'hA5, 1'b0}, 9, 10);
    chk(rx_ferr == 1'b1, "R8 ferr set", {31'h0, rx_ferr}, 1);
    chk(rx_valid == 1'b1 && rx_data == 8'hA5, "R8 data kept", {23'h0, rx_valid, rx_data}, 32'h1A5);
    rx_read();
    drive_rx({3'b111, 8'h5A, 1'b0}, 10, 0);
    chk(rx_ferr == 1'b0, "R8 ferr cleared", {31'h0, rx_ferr}, 0);
    rx_read();
    use_loop = 1'b1;

    // R9: second character lost while the first is unread
    mp_en = 1'b1;
    xfer(8'h11, 1'b1, 1, "R3 frame A");
    repeat (24) @(negedge clk);
    xfer(8'h22, 1'b0, 1, "R3 frame B");
    repeat (24) @(negedge clk);
    chk(rx_overrun == 1'b1, "R9 overrun", {31'h0, rx_overrun}, 1);
    chk(rx_data == 8'h11, "R9 data kept", {24'h0, rx_data}, 32'h11);
    chk(rx_mpb == 1'b1, "R7 tag of kept char", {31'h0, rx_mpb}, 1);
    exp_mpb = 1'b1;
    rx_read();

    // R10: read pulse swept across the completion of an overlapping character
    seen_new = 0; seen_lost = 0;
    for (int off = 160; off < 186; off++) begin
      a = 8'($urandom);
      xfer(a, 1'b0, 1, "R3 frame sweep A");
      repeat (24) @(negedge clk);
      fork
        send(~a, 1'b1);
        begin
          @(negedge txd);
          repeat (off) @(negedge clk);
          rx_rd = 1'b1;
          @(negedge clk); rx_rd = 1'b0;
        end
      join
      repeat (80) @(negedge clk);
      if (rx_overrun == 1'b0 && rx_valid == 1'b1 && rx_data == ~a) seen_new++;
      else if (rx_overrun == 1'b1 && rx_valid == 1'b0 && rx_data == a) seen_lost++;
      else chk(1'b0, "R10 race outcome", {22'h0, rx_overrun, rx_valid, rx_data}, {24'h0, ~a});
      rx_read();
    end
    exp_mpb = rx_mpb;
    chk(seen_new > 0 && seen_lost > 0, "R10 both outcomes", seen_new, seen_lost);

    // R2: slower rates, low run of start plus eight zero bits
    brr_write(8'h02); clk_sel = 2'd1;
    repeat (40) @(negedge clk);
    period_check(12, "R2 period sel1 n2");
    brr_write(8'h00); clk_sel = 2'd3;
    repeat (140) @(negedge clk);
    period_check(64, "R2 period sel3 n0");

    summary();
  end
endmodule